// File: doc/BRIEF.md
# Isolation-Tagged Branch Target Buffer

This block is a small direct-mapped branch target buffer for an in-order core that runs two hardware threads. The fetch stage presents a fetch address together with the current privilege level and thread number, and gets back a hit flag and a predicted target in the same cycle. The branch resolution stage writes taken branches into the buffer through an update port.

Each entry records the privilege level and the thread that trained it. A stored target is returned only to a requester in the same privilege level. It must also come from the same thread, unless a sharing bit in the block's configuration register allows threads to use each other's entries. Two flush inputs wipe the whole buffer. One is raised automatically by the core on a context change such as a system call. The other is a barrier that system software issues on a process switch.

Top module: `itag_btb`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses. The sharing bit resets to 0, meaning sharing is disabled.
- R2: When `upd_en` is high and no flush is requested, the entry selected by `upd_pc[5:2]` is written at the clock edge with the tag `upd_pc[31:6]`, the target, `upd_kernel` and `upd_tid`. From the next cycle on, a lookup with a matching address, mode and thread returns `look_hit`=1 and that target combinationally, in the cycle of the request.
- R3: A lookup whose index matches a valid entry but whose address bits [31:6] differ from the stored tag misses. A later update to the same index replaces the earlier entry.
- R4: A lookup whose `look_kernel` differs from the entry's stored mode bit misses. Whenever `look_hit` is 0, `look_target` is 0, so no stored target leaks on a miss.
- R5: While sharing is disabled, a lookup from a thread other than the one that trained the entry misses.
- R6: While sharing is enabled, an entry hits for either thread, and the mode check still applies.
- R7: A high `ctx_change` invalidates every entry at the next clock edge.
- R8: A high `flush_barrier` invalidates every entry at the next clock edge.
- R9: When a flush and an update occur in the same cycle, the flush wins and the update is not stored.
- R10: The sharing bit loads `cfg_share` only in a cycle where `cfg_we` is high. Otherwise it keeps its value, whatever `cfg_share` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| look_pc | input | 32 | Fetch address to look up |
| look_kernel | input | 1 | Current mode, 1 = kernel |
| look_tid | input | 1 | Requesting hardware thread |
| look_hit | output | 1 | Prediction available |
| look_target | output | 32 | Predicted target, 0 on a miss |
| upd_en | input | 1 | Write a resolved taken branch |
| upd_pc | input | 32 | Branch address |
| upd_target | input | 32 | Resolved target |
| upd_kernel | input | 1 | Mode the branch ran in |
| upd_tid | input | 1 | Thread that ran the branch |
| ctx_change | input | 1 | Automatic flush on a context change |
| flush_barrier | input | 1 | Software-requested flush |
| cfg_we | input | 1 | Write enable for the sharing bit |
| cfg_share | input | 1 | New sharing bit, 1 = threads may share entries |

## Verification
On every cycle, the in-module assertions check four things. A flush leaves the buffer empty and the next lookup a miss. An unflushed update leaves its entry valid. The sharing bit is stable without a write. A miss never drives a target. The isolation rules themselves need the bench's scenarios. These include cross-mode and cross-thread lookups of the same address, tag aliasing on one index, toggling the sharing bit, and a flush that coincides with an update. In each scenario a behavioural model of the trained branches predicts the answer every clock.

// File: rtl/itag_btb.sv
module itag_btb #(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 32,
  parameter int THREADS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] look_pc,
  input  logic              look_kernel,
  input  logic              look_tid,
  output logic              look_hit,
  output logic [ADDR_W-1:0] look_target,
  input  logic              upd_en,
  input  logic [ADDR_W-1:0] upd_pc,
  input  logic [ADDR_W-1:0] upd_target,
  input  logic              upd_kernel,
  input  logic              upd_tid,
  input  logic              ctx_change,
  input  logic              flush_barrier,
  input  logic              cfg_we,
  input  logic              cfg_share
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = ADDR_W - IDX_W - 2;
  localparam int TID_W = (THREADS > 1) ? $clog2(THREADS) : 1;

  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  logic [ADDR_W-1:0]  tgt_q  [ENTRIES];
  logic [ENTRIES-1:0] kern_q;
  logic [TID_W-1:0]   tid_q  [ENTRIES];
  logic               share_q;

  wire flush = ctx_change | flush_barrier;
  wire [IDX_W-1:0] look_idx = look_pc[IDX_W+1:2];
  wire [IDX_W-1:0] upd_idx  = upd_pc[IDX_W+1:2];
  wire [TID_W-1:0] look_t   = TID_W'(look_tid);

  wire tag_ok  = tag_q[look_idx] == look_pc[ADDR_W-1:IDX_W+2];
  wire mode_ok = kern_q[look_idx] == look_kernel;
  wire tid_ok  = share_q || (tid_q[look_idx] == look_t);

  assign look_hit    = valid_q[look_idx] && tag_ok && mode_ok && tid_ok;
  assign look_target = look_hit ? tgt_q[look_idx] : '0;

  logic unused_ok;
  assign unused_ok = ^{look_pc[1:0], upd_pc[1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      share_q <= 1'b0;
    end else begin
      if (cfg_we) share_q <= cfg_share;
      if (flush) valid_q <= '0;
      else if (upd_en) valid_q[upd_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (upd_en && !flush) begin
      tag_q[upd_idx]  <= upd_pc[ADDR_W-1:IDX_W+2];
      tgt_q[upd_idx]  <= upd_target;
      kern_q[upd_idx] <= upd_kernel;
      tid_q[upd_idx]  <= TID_W'(upd_tid);
    end
  end

  // R7 R8 R9
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_q == '0) && !look_hit);

  // R2
  train_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !flush) |=> valid_q[$past(upd_idx)]);

  // R10
  share_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(share_q));

  // R4
  miss_no_leak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !look_hit |-> (look_target == '0));
endmodule

// File: tb/itag_btb_test.sv
module itag_btb_test;
  logic clk = 0, rst_n = 0;
  logic [31:0] look_pc = 0, upd_pc = 0, upd_target = 0;
  logic look_kernel = 0, look_tid = 0, upd_en = 0, upd_kernel = 0, upd_tid = 0;
  logic ctx_change = 0, flush_barrier = 0, cfg_we = 0, cfg_share = 0;
  logic look_hit;
  logic [31:0] look_target;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  typedef struct { logic [31:0] pc; logic [31:0] tgt; logic k; logic t; } br_t;
  br_t trained[$];
  bit share_m = 0;

  itag_btb uut (.*);

  always #10 clk = ~clk;

  task automatic predict(output logic h, output logic [31:0] t);
    h = 0; t = 0;
    for (int i = trained.size() - 1; i >= 0; i--) begin
      if (trained[i].pc[5:2] == look_pc[5:2]) begin
        if (trained[i].pc[31:6] == look_pc[31:6] && trained[i].k == look_kernel &&
            (share_m || trained[i].t == look_tid)) begin
          h = 1; t = trained[i].tgt;
        end
        return;
      end
    end
  endtask

  task automatic step(input string req, input logic [31:0] lpc, input logic lk, input logic lt,
                      input logic ue = 0, input logic [31:0] upc = 0, input logic [31:0] utg = 0,
                      input logic uk = 0, input logic ut = 0, input logic cc = 0,
                      input logic fb = 0, input logic cw = 0, input logic cs = 0);
    logic eh; logic [31:0] et;
    @(negedge clk);
    look_pc = lpc; look_kernel = lk; look_tid = lt;
    upd_en = ue; upd_pc = upc; upd_target = utg; upd_kernel = uk; upd_tid = ut;
    ctx_change = cc; flush_barrier = fb; cfg_we = cw; cfg_share = cs;
    #2;
    predict(eh, et);
    checks++;
    if (look_hit !== eh || look_target !== et) begin
      errors++;
      $display("FAIL %s: hit=%0b target=%h expected hit=%0b target=%h", req, look_hit, look_target, eh, et);
    end
    if (cc || fb) trained.delete();
    else if (ue) trained.push_back('{pc: upc, tgt: utg, k: uk, t: ut});
    if (cw) share_m = cs;
  endtask

  localparam logic [31:0] A = 32'h1000_0040;
  localparam logic [31:0] B = 32'h2000_00CC;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    step("R1", A, 0, 0);
    step("R1", B, 1, 1);
    step("R2", A, 0, 0, 1, A, 32'hAAAA_0000, 0, 0);
    step("R2", A, 0, 0);
    step("R4", A, 1, 0);
    step("R5", A, 0, 1);
    step("R1", A, 0, 1);
    step("R3", A + 32'h1000, 0, 0);
    step("R6", A, 0, 1, 0, 0, 0, 0, 0, 0, 0, 1, 1);
    step("R6", A, 0, 1);
    step("R6", A, 1, 1);
    step("R10", A, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R10", A, 0, 1);
    step("R5", A, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    step("R5", A, 0, 1);
    step("R2", B, 1, 1, 1, B, 32'hBBBB_0004, 1, 1);
    step("R2", B, 1, 1);
    step("R4", B, 0, 1);
    step("R3", B, 1, 1, 1, B + 32'h40, 32'hCCCC_0008, 1, 1);
    step("R3", B, 1, 1);
    step("R3", B + 32'h40, 1, 1);
    step("R7", A, 0, 0, 0, 0, 0, 0, 0, 1);
    step("R7", A, 0, 0);
    step("R7", B + 32'h40, 1, 1);
    for (int i = 0; i < 16; i++)
      step("R2", A, 0, 0, 1, 32'h3000_0000 + i * 4, 32'h4000_0000 + i, i[0], i[1]);
    for (int i = 0; i < 16; i++)
      step("R2", 32'h3000_0000 + i * 4, i[0], i[1]);
    step("R8", A, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    for (int i = 0; i < 16; i++)
      step("R8", 32'h3000_0000 + i * 4, i[0], i[1]);
    step("R9", A, 0, 0, 1, A, 32'h5555_0000, 0, 0, 0, 1);
    step("R9", A, 0, 0);
    step("R9", A, 0, 0, 1, A, 32'h6666_0000, 0, 0, 1, 0);
    step("R9", A, 0, 0);
    step("R2", A, 0, 0, 1, A, 32'h7777_0000, 0, 0);
    step("R2", A, 0, 0);
    done = 1;
  end

  initial begin
    while (!done && cycles < 5000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: hung run, expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule